// File: doc/BRIEF.md
# Peripheral-Paced Single-Channel DMA Engine

This block moves a stream of data words from one peripheral data register into a run of consecutive memory locations, so the processor does not have to copy each word itself. Before a run, the processor writes a source address, a destination address, a byte length and an interrupt enable through a four-entry register window. It then sets the start bit. After that, the peripheral paces the engine: each time the peripheral raises its request line, the engine fetches one word from the fixed source address.

Each word crosses the shared memory bus twice. First it is read into a small internal FIFO. Later it is written from the FIFO to the current destination, and the destination then moves forward by one word. The engine and the processor share the bus. The engine raises a bus request and drives the bus only while an external arbiter grants it. It keeps the grant for exactly one complete access and then gives it back. When the last word has been written, the engine clears its busy flag and sets a done flag. If the interrupt is enabled, it also holds a level interrupt until software clears the done flag.

Register window, selected by `reg_sel`: 0 source address, 1 destination address, 2 remaining byte length, 3 control/status. On a write to entry 3, bit 0 starts a run, bit 1 is the interrupt enable taken at start, and bit 2 written as 1 clears done. On a read of entry 3, bit 0 is busy, bit 1 is the interrupt enable and bit 2 is done.

Top module: `pdma_engine`

## Requirements
- R1: After reset the engine is idle. The status reads 0, `irq`, `bus_req`, `m_valid` and `prq_ack` are low, and the address and length entries read 0. A start (bit 0 of a write to entry 3) with a nonzero length makes the busy status bit (bit 0) read 1 from the next cycle.
- R2: Every read access the engine issues has `m_write` low and `m_addr` equal to the programmed source address. The source entry keeps its value through the run.
- R3: The k-th write access of a run (k from 0) goes to destination + 4·k. After each completed write, the destination entry has grown by 4 and the length entry has shrunk by 4. At the end of the run they read destination + 4·n and 0.
- R4: A read access is issued only while `prq_req` is high. `prq_ack` is high for exactly the cycle in which a read completes (`m_valid` and `m_ready` both high) and is low in every other cycle. There is one acknowledge per element.
- R5: Each element is first read and then written. The written data arrives in the same order as it was read, and a run of n elements performs exactly n writes.
- R6: `m_valid` is high only while `bus_gnt` is high. `bus_req` stays high until the grant arrives. `bus_req` is low in the cycle after an access completes, so the engine never overlaps a processor bus tenure.
- R7: The number of elements read but not yet written never exceeds FIFO_DEPTH. A peripheral request that arrives while the FIFO is full waits, unacknowledged, until a write frees space.
- R8: After the last write, busy (status bit 0) reads 0 and done (status bit 2) reads 1. `irq` then equals the interrupt enable given at start.
- R9: Writing entry 3 with bit 2 set and bit 0 clear sets done to 0 and drops `irq` in the next cycle.
- R10: While busy, a start is ignored and leaves the interrupt enable unchanged. Writes to the source, destination and length entries are also ignored while busy.
- R11: The two low bits of a written length are dropped, so a length of 3 reads back as 0. A start with length 0 sets done at once (and `irq` if enabled) and raises no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register window write strobe |
| reg_sel | input | 2 | Register entry select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for the selected entry |
| irq | output | 1 | Level interrupt: done and enabled |
| prq_req | input | 1 | Peripheral has a new word |
| prq_ack | output | 1 | Word taken from the peripheral |
| bus_req | output | 1 | Engine wants the shared bus |
| bus_gnt | input | 1 | Engine owns the shared bus |
| m_valid | output | 1 | Bus access in progress |
| m_write | output | 1 | Access is a write |
| m_addr | output | AW | Access address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| m_ready | input | 1 | Access completes this cycle |

## Verification
The bench builds the engine with a 32-bit address and data path, a 16-bit length and FIFO_DEPTH of 2. The shallow FIFO means a peripheral that requests every cycle fills the FIFO within two reads, so the stalled-request path of R7 is reached in a directed case and often in the random runs. Random bus-ready delays, processor bus tenures and peripheral pacing shift reads and writes against each other in many orders. The directed cases cover a zero length, a length with low bits set, and configuration writes made while busy.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   typedef enum logic [2:0] {
      ST_PICK,
      ST_RREQ,
      ST_READ,
      ST_WREQ,
      ST_WRITE
   } seq_st_t;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_LEN = 2'd2;
   localparam logic [1:0] SEL_CSR = 2'd3;

   localparam int CTL_GO   = 0;
   localparam int CTL_IEN  = 1;
   localparam int CTL_DONE = 2;
endpackage

// File: rtl/pdma_fifo.sv
module pdma_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   generate
      if (DEPTH == 1) begin : g_single
         logic          vld_q;
         logic [DW-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               if (push) begin
                  vld_q <= 1'b1;
                  dat_q <= din;
               end else if (pop) begin
                  vld_q <= 1'b0;
               end
            end
         end
         assign dout  = dat_q;
         assign full  = vld_q;
         assign empty = !vld_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [DW-1:0] mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [PW:0]   cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) begin
                  mem_q[wp_q] <= din;
                  wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
               end
               if (pop) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
               if (push && !pop) cnt_q <= cnt_q + (PW+1)'(1);
               else if (pop && !push) cnt_q <= cnt_q - (PW+1)'(1);
            end
         end
         assign dout  = mem_q[rp_q];
         assign full  = (cnt_q == (PW+1)'(DEPTH));
         assign empty = (cnt_q == '0);
      end
   endgenerate

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R5
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
   import pdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          rd_beat,
   input  logic          wr_beat,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic          busy,
   output logic          rd_pend,
   output logic          irq
);
   localparam int EB = DW / 8;
   localparam int SH = $clog2(EB);

   logic [AW-1:0] src_q, dst_q;
   logic [LW-1:0] len_q, rd_left_q;
   logic          busy_q, done_q, ien_q;
   logic          csr_wr;

   assign csr_wr = reg_we && (reg_sel == SEL_CSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q     <= '0;
         dst_q     <= '0;
         len_q     <= '0;
         rd_left_q <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         ien_q     <= 1'b0;
      end else begin
         if (reg_we && !busy_q) begin
            case (reg_sel)
               SEL_SRC: src_q <= reg_wdata[AW-1:0];
               SEL_DST: dst_q <= reg_wdata[AW-1:0];
               SEL_LEN: len_q <= reg_wdata[LW-1:0] & ~LW'(EB - 1);
               default: ;
            endcase
         end
         if (csr_wr) begin
            if (reg_wdata[CTL_DONE]) done_q <= 1'b0;
            if (reg_wdata[CTL_GO] && !busy_q) begin
               ien_q     <= reg_wdata[CTL_IEN];
               busy_q    <= (len_q != '0);
               done_q    <= (len_q == '0);
               rd_left_q <= len_q >> SH;
            end
         end
         if (rd_beat) rd_left_q <= rd_left_q - LW'(1);
         if (wr_beat) begin
            dst_q <= dst_q + AW'(EB);
            len_q <= len_q - LW'(EB);
            if (len_q == LW'(EB)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_SRC: reg_rdata = DW'(src_q);
         SEL_DST: reg_rdata = DW'(dst_q);
         SEL_LEN: reg_rdata = DW'(len_q);
         default: begin
            reg_rdata[0]        = busy_q;
            reg_rdata[CTL_IEN]  = ien_q;
            reg_rdata[CTL_DONE] = done_q;
         end
      endcase
   end

   assign src_addr = src_q;
   assign dst_addr = dst_q;
   assign busy     = busy_q;
   assign rd_pend  = (rd_left_q != '0);
   assign irq      = done_q && ien_q;

   AST_DST_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                      wr_beat |=> dst_q == $past(dst_q) + AW'(EB));  // R3
   AST_SRC_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
                      (busy_q && $past(busy_q)) |-> $stable(src_q));  // R2
   AST_START_IGN:  assert property (@(posedge clk) disable iff (!rst_n)
                      (csr_wr && reg_wdata[CTL_GO] && busy_q) |=> $stable(ien_q));  // R10
   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                      (csr_wr && reg_wdata[CTL_DONE] && !reg_wdata[CTL_GO]) |=> !irq);  // R9
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
   import pdma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_pend,
   input  logic prq_req,
   input  logic fifo_full,
   input  logic fifo_empty,
   input  logic bus_gnt,
   input  logic m_ready,
   output logic bus_req,
   output logic m_valid,
   output logic m_write,
   output logic rd_beat,
   output logic wr_beat
);
   seq_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_PICK:
            if (busy && prq_req && rd_pend && !fifo_full) st_d = ST_RREQ;
            else if (!fifo_empty)                         st_d = ST_WREQ;
         ST_RREQ:  if (bus_gnt) st_d = ST_READ;
         ST_READ:  if (m_ready) st_d = ST_PICK;
         ST_WREQ:  if (bus_gnt) st_d = ST_WRITE;
         ST_WRITE: if (m_ready) st_d = ST_PICK;
         default:  st_d = ST_PICK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_PICK;
      else        st_q <= st_d;
   end

   assign bus_req = (st_q != ST_PICK);
   assign m_valid = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign m_write = (st_q == ST_WRITE);
   assign rd_beat = (st_q == ST_READ) && m_ready;
   assign wr_beat = (st_q == ST_WRITE) && m_ready;

   AST_BUS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
                     m_valid |-> bus_gnt);  // R6
   AST_REQ_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                     (bus_req && !bus_gnt) |=> bus_req);  // R6
   AST_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n)
                     (m_valid && m_ready) |=> !bus_req);  // R6
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                     rd_beat |=> !rd_beat);  // R4
   AST_READ_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(m_valid && !m_write) |-> $past(prq_req));  // R4
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine #(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LW         = 16,
   parameter int FIFO_DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          irq,
   input  logic          prq_req,
   output logic          prq_ack,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          m_valid,
   output logic          m_write,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_wdata,
   input  logic [DW-1:0] m_rdata,
   input  logic          m_ready
);
   generate
      if ((DW % 8) != 0 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("pdma_engine: DW must be a power of two multiple of 8");
      end
      if (AW > DW || LW > DW || LW < 3) begin : g_bad_aw
         $error("pdma_engine: AW and LW must fit the register width");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("pdma_engine: FIFO_DEPTH must be at least 1");
      end
   endgenerate

   logic [AW-1:0] src_addr, dst_addr;
   logic          busy, rd_pend, rd_beat, wr_beat, fifo_full, fifo_empty;

   pdma_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .rd_beat   (rd_beat),
      .wr_beat   (wr_beat),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .busy      (busy),
      .rd_pend   (rd_pend),
      .irq       (irq)
   );

   pdma_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .rd_pend    (rd_pend),
      .prq_req    (prq_req),
      .fifo_full  (fifo_full),
      .fifo_empty (fifo_empty),
      .bus_gnt    (bus_gnt),
      .m_ready    (m_ready),
      .bus_req    (bus_req),
      .m_valid    (m_valid),
      .m_write    (m_write),
      .rd_beat    (rd_beat),
      .wr_beat    (wr_beat)
   );

   pdma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rd_beat),
      .din   (m_rdata),
      .pop   (wr_beat),
      .dout  (m_wdata),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   assign m_addr  = m_write ? dst_addr : src_addr;
   assign prq_ack = rd_beat;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                      (!busy && fifo_empty) |-> !m_valid);  // R8
endmodule

// File: tb/pdma_engine_tb.sv
module pdma_engine_tb;
   localparam int AW = 32, DW = 32, LW = 16, DEPTH = 2;
   localparam logic [31:0] PADDR = 32'h4000_0010;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic irq, prq_req = 1'b0, prq_ack, bus_req, bus_gnt = 1'b0;
   logic m_valid, m_write, m_ready = 1'b0;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata, m_rdata = '0;

   int checks = 0, failures = 0;
   int pk = 0, wk = 0, n_target = 0, cpu_left = 0;
   int per_rate = 1, rdy_rate = 1, cpu_rate = 0;
   int max_occ = 0, ack_cnt = 0, breq_cycles = 0;
   logic [31:0] exp_dst = '0, salt = 32'h1234_5678;
   bit finished = 0;

   pdma_engine #(.AW(AW), .DW(DW), .LW(LW), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .prq_req(prq_req), .prq_ack(prq_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_ready(m_ready));

   always #4 clk = ~clk;

   function automatic logic [31:0] pdata(int k);
      return (32'(k) * 32'h9E37_79B9) ^ salt;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      int occ;
      chk(!prq_ack, "R4 ack outside read completion", 32'(prq_ack), 0);
      if (m_valid) chk(bus_gnt, "R6 access without grant", 32'(bus_gnt), 1);
      if (m_valid && !m_write) chk(prq_req, "R4 read without request", 32'(prq_req), 1);
      if (bus_req) breq_cycles++;
      if (m_ready) m_ready = 1'b0;
      else if (m_valid && ($urandom % rdy_rate == 0)) begin
         m_ready = 1'b1;
         if (!m_write) begin
            chk(m_addr == PADDR, "R2 read address", m_addr, PADDR);
            m_rdata = pdata(pk);
            #1;
            chk(prq_ack, "R4 ack at read completion", 32'(prq_ack), 1);
            prq_req = 1'b0;
            pk++;
            ack_cnt++;
            occ = pk - wk;
            if (occ > max_occ) max_occ = occ;
            chk(occ <= DEPTH, "R7 elements held", 32'(occ), 32'(DEPTH));
         end else begin
            chk(m_addr == exp_dst, "R3 write address", m_addr, exp_dst);
            chk(m_wdata == pdata(wk), "R5 write data order", m_wdata, pdata(wk));
            wk++;
            exp_dst += 4;
         end
      end
      if (bus_gnt) begin
         if (!bus_req) bus_gnt = 1'b0;
      end else if (cpu_left > 0) begin
         cpu_left--;
      end else if (bus_req && ($urandom % 2 == 0)) begin
         bus_gnt = 1'b1;
      end else if (cpu_rate != 0 && ($urandom % cpu_rate == 0)) begin
         cpu_left = 1 + int'($urandom % 5);
      end
      if (!prq_req && pk < n_target && ($urandom % per_rate == 0)) prq_req = 1'b1;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) model_step();
      end
   end

   task automatic reg_write(logic [1:0] sel, logic [31:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] sel, output logic [31:0] val);
      @(negedge clk);
      reg_sel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic run(int n, int low, bit ien, logic [31:0] base, bit inject);
      logic [31:0] st, v;
      int t;
      pk = 0; wk = 0; ack_cnt = 0; max_occ = 0; n_target = n; exp_dst = base;
      salt = $urandom;
      reg_write(2'd0, PADDR);
      reg_write(2'd1, base);
      reg_write(2'd2, 32'(n * 4 + low));
      reg_write(2'd3, {29'd0, 1'b0, ien, 1'b1});
      reg_read(2'd3, st);
      chk(st[0] == 1'b1, "R1 busy after start", st, 32'h1);
      if (inject) begin
         reg_write(2'd1, 32'h3000_0000);
         reg_write(2'd2, 32'h40);
         reg_write(2'd0, 32'h0);
         reg_write(2'd3, {29'd0, 1'b0, !ien, 1'b1});
      end
      t = 0;
      do begin reg_read(2'd3, st); t++; end while (!st[2] && t < 5000);
      chk(st[2] && !st[0], "R8 done and not busy", st, 32'h4);
      chk(st[1] == ien, "R10 enable kept", 32'(st[1]), 32'(ien));
      @(negedge clk);
      chk(irq == ien, "R8 irq follows enable", 32'(irq), 32'(ien));
      chk(wk == n, "R5 write count", 32'(wk), 32'(n));
      chk(ack_cnt == n, "R4 ack count", 32'(ack_cnt), 32'(n));
      reg_read(2'd1, v);
      chk(v == base + 32'(4 * n), "R3 final destination", v, base + 32'(4 * n));
      reg_read(2'd2, v);
      chk(v == 0, "R3 final length", v, 0);
      reg_read(2'd0, v);
      chk(v == PADDR, "R10 source kept", v, PADDR);
      reg_write(2'd3, 32'h4);
      reg_read(2'd3, st);
      chk(st[2] == 1'b0 && !irq, "R9 done cleared", st, 32'(ien) << 1);
   endtask

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      reg_read(2'd3, v);
      chk(v == 0, "R1 reset status", v, 0);
      chk(!irq && !bus_req && !m_valid && !prq_ack, "R1 reset outputs",
          {28'd0, irq, bus_req, m_valid, prq_ack}, 0);
      reg_read(2'd1, v);
      chk(v == 0, "R1 reset destination", v, 0);

      reg_write(2'd2, 32'd3);
      reg_read(2'd2, v);
      chk(v == 0, "R11 low length bits dropped", v, 0);
      breq_cycles = 0; n_target = 0;
      reg_write(2'd3, 32'h3);
      reg_read(2'd3, v);
      chk(v[2] && !v[0], "R11 zero length done", v, 32'h6);
      chk(irq, "R11 zero length irq", 32'(irq), 1);
      repeat (5) @(negedge clk);
      chk(breq_cycles == 0, "R11 no bus request", 32'(breq_cycles), 0);
      reg_write(2'd3, 32'h4);

      run(5, 0, 1'b1, 32'h2000_0100, 1'b0);
      per_rate = 10; rdy_rate = 2;
      run(12, 2, 1'b0, 32'h2000_0200, 1'b1);

      per_rate = 1; rdy_rate = 3; cpu_rate = 0;
      run(10, 0, 1'b1, 32'h2000_0300, 1'b0);
      chk(max_occ == DEPTH, "R7 FIFO reaches full", 32'(max_occ), 32'(DEPTH));

      for (int r = 0; r < 14; r++) begin
         per_rate = 1 + int'($urandom % 6);
         rdy_rate = 1 + int'($urandom % 3);
         cpu_rate = int'($urandom % 4);
         run(1 + int'($urandom % 20), int'($urandom % 4), 1'($urandom % 2),
             32'h2000_0000 + 32'(($urandom % 64) * 4), 1'b0);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule